// File: doc/BRIEF.md
# Video Output Compositor

This block drives the display side of a video pipeline. On every pixel clock it advances a line and field raster, raises a composite blanking flag outside the active picture region and marks odd fields with an active-high flag. The active region is 720 clocks wide in both supported standards. A line lasts 858 clocks in the 60 Hz standard and 864 clocks in the 50 Hz standard. A field holds 240 or 288 active lines, followed by a few lines of vertical blanking.

A decoded picture, smaller than the active region, is placed inside it. By default the picture is centred on an even column and an even row. Programmable shifts move it left, right, up or down in steps of two. The block asks an external pixel source for each picture pixel by column and row, and the source answers one clock later. Active pixels outside the picture take one of four fixed background colours. The picture can be mirrored horizontally. Any part of the picture that a shift pushes past the edge of the active region is dropped. Luma and interleaved Cb/Cr leave the block on two 8-bit buses. All placement and appearance inputs are sampled once per field, so a picture is never torn.

Top module: `vout_compositor`

## Requirements
- R1: Each line has ACT_W (720) active clocks first and then horizontal blanking. The line total is 858 clocks when `palMode` is 0 and 864 clocks when it is 1. `blankOut` is 1 at every position outside the active region.
- R2: Each field has its active lines first (240 when `palMode`=0, 288 when 1), followed by VBL_A (22) or VBL_B (24) blanking lines.
- R3: `oddFieldOut` is 1 for the first field after reset and inverts at the start of every later field.
- R4: At an active position outside the picture, the output is the background colour chosen by `bgSelect`, given as (Y, Cb, Cr): 0 black (16,128,128), 1 green (145,54,34), 2 blue (41,240,110), 3 purple (106,202,222). `chromaOut` carries Cb on even active columns and Cr on odd ones, counting from column 0. During blanking the output is Y=16, C=128.
- R5: The picture origin column is floor((ACT_W − picWidth)/4)·2, plus 2·`hShiftMag` (or minus it when `hShiftLeft`=1). The origin row is found the same way, using the active line count, `picHeight`, `vShiftMag` and `vShiftUp`.
- R6: For every position inside the picture, `pixReq` is 1 and `pixCol`/`pixRow` give the position relative to the origin. `pixReq` is 0 everywhere else. The source data that arrives in the next cycle appears on `lumaOut`/`chromaOut` two cycles after the request.
- R7: Picture positions beyond the active region are not shown and do not wrap. Positions left of column 0 or above row 0 are also dropped.
- R8: With `mirrorEn`=1, the requested column is picWidth−1 minus the relative column.
- R9: All configuration inputs are sampled only on the last clock of a field. A change made at any other time has no effect until the next field.
- R10: After reset, `blankOut`=1, `lumaOut`=16, `chromaOut`=128, `oddFieldOut`=0 and `pixReq`=0 until the first field begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| palMode | input | 1 | Standard select: 0 = 858-clock lines, 1 = 864-clock lines |
| picWidth | input | PW_BITS | Picture width in pixels |
| picHeight | input | PH_BITS | Picture height in lines |
| hShiftMag | input | 6 | Horizontal shift in units of two pixels |
| hShiftLeft | input | 1 | 1 = shift left, 0 = shift right |
| vShiftMag | input | 5 | Vertical shift in units of two lines |
| vShiftUp | input | 1 | 1 = shift up, 0 = shift down |
| bgSelect | input | 2 | Background colour code |
| mirrorEn | input | 1 | Horizontal mirror enable |
| pixReq | output | 1 | Picture pixel request |
| pixCol | output | PW_BITS | Requested picture column |
| pixRow | output | PH_BITS | Requested picture row |
| srcLuma | input | 8 | Source luma, valid one clock after the request |
| srcChroma | input | 8 | Source chroma, valid one clock after the request |
| blankOut | output | 1 | Composite blanking, high outside active video |
| oddFieldOut | output | 1 | Odd field flag, active high |
| lumaOut | output | 8 | Output luma |
| chromaOut | output | 8 | Output Cb/Cr, interleaved |

## Verification
The hardest situations to reach are a configuration change that lands in the middle of a field, and a picture that is mirrored and clipped at the same time. In the second case the clipped columns must disappear from the correct side. The bench shrinks the raster through parameters so that dozens of fields fit into a short run. It changes every setting on cycles that have no relation to field boundaries, so each field both holds one setting and picks up a new one. It also uses pictures wider or taller than the active region together with maximum shifts in both directions, with mirroring on and off.

// File: rtl/vout_pkg.sv
package vout_pkg;

  typedef struct packed {
    logic       blank;
    logic       pic;
    logic       crPhase;
    logic       oddField;
    logic [1:0] bgSel;
  } strobe_t;

  localparam logic [7:0] BLANK_LUMA   = 8'd16;
  localparam logic [7:0] BLANK_CHROMA = 8'd128;

  // returns {Y, Cb, Cr}
  function automatic logic [23:0] bgColour(input logic [1:0] sel);
    case (sel)
      2'd1:    return {8'd145, 8'd54,  8'd34};
      2'd2:    return {8'd41,  8'd240, 8'd110};
      2'd3:    return {8'd106, 8'd202, 8'd222};
      default: return {8'd16,  8'd128, 8'd128};
    endcase
  endfunction

endpackage

// File: rtl/vout_timing_ctrl.sv
module vout_timing_ctrl
  import vout_pkg::*;
#(
  parameter int ACT_W       = 720,
  parameter int LINE_A      = 858,
  parameter int LINE_B      = 864,
  parameter int ACT_LINES_A = 240,
  parameter int ACT_LINES_B = 288,
  parameter int VBL_A       = 22,
  parameter int VBL_B       = 24,
  parameter int PW_BITS     = 10,
  parameter int PH_BITS     = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               palMode,
  input  logic [PW_BITS-1:0] picWidth,
  input  logic [PH_BITS-1:0] picHeight,
  input  logic [5:0]         hShiftMag,
  input  logic               hShiftLeft,
  input  logic [4:0]         vShiftMag,
  input  logic               vShiftUp,
  input  logic [1:0]         bgSelect,
  input  logic               mirrorEn,
  output logic               pixReq,
  output logic [PW_BITS-1:0] pixCol,
  output logic [PH_BITS-1:0] pixRow,
  output strobe_t            strobe
);

  localparam int LINE_MAX  = (LINE_A > LINE_B) ? LINE_A : LINE_B;
  localparam int FIELD_A   = ACT_LINES_A + VBL_A;
  localparam int FIELD_B   = ACT_LINES_B + VBL_B;
  localparam int FIELD_MAX = (FIELD_A > FIELD_B) ? FIELD_A : FIELD_B;
  localparam int HW        = $clog2(LINE_MAX);
  localparam int VW        = $clog2(FIELD_MAX);
  localparam int XMAX      = (PW_BITS > HW) ? PW_BITS : HW;
  localparam int YMAX      = (PH_BITS > VW) ? PH_BITS : VW;
  localparam int SW        = ((XMAX > YMAX) ? XMAX : YMAX) + 3;

  logic [HW-1:0] hCount;
  logic [VW-1:0] vCount;
  logic          oddField;

  // field-latched configuration
  logic               curPal;
  logic [PW_BITS-1:0] curW;
  logic [PH_BITS-1:0] curH;
  logic [5:0]         curHMag;
  logic               curHLeft;
  logic [4:0]         curVMag;
  logic               curVUp;
  logic [1:0]         curBg;
  logic               curMirror;

  logic [HW-1:0] lineLast;
  logic [VW-1:0] fieldLast;
  logic [VW-1:0] actLines;
  logic          lineEnd, fieldEnd, activeNow;

  always_comb begin
    lineLast  = curPal ? HW'(LINE_B - 1)  : HW'(LINE_A - 1);
    fieldLast = curPal ? VW'(FIELD_B - 1) : VW'(FIELD_A - 1);
    actLines  = curPal ? VW'(ACT_LINES_B) : VW'(ACT_LINES_A);
    lineEnd   = (hCount == lineLast);
    fieldEnd  = lineEnd && (vCount == fieldLast);
    activeNow = (hCount < HW'(ACT_W)) && (vCount < actLines);
  end

  // raster counters and field flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCount   <= HW'(LINE_A - 1);
      vCount   <= VW'(FIELD_A - 1);
      oddField <= 1'b0;
    end else begin
      if (lineEnd) begin
        hCount <= '0;
        if (fieldEnd) begin
          vCount   <= '0;
          oddField <= ~oddField;
        end else begin
          vCount <= vCount + 1'b1;
        end
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  // configuration shadow, loaded on the last clock of a field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPal    <= 1'b0;
      curW      <= '0;
      curH      <= '0;
      curHMag   <= '0;
      curHLeft  <= 1'b0;
      curVMag   <= '0;
      curVUp    <= 1'b0;
      curBg     <= '0;
      curMirror <= 1'b0;
    end else if (fieldEnd) begin
      curPal    <= palMode;
      curW      <= picWidth;
      curH      <= picHeight;
      curHMag   <= hShiftMag;
      curHLeft  <= hShiftLeft;
      curVMag   <= vShiftMag;
      curVUp    <= vShiftUp;
      curBg     <= bgSelect;
      curMirror <= mirrorEn;
    end
  end

  // window geometry in signed arithmetic
  logic signed [SW-1:0] wS, hS, hcS, vcS, actWS, actLS;
  logic signed [SW-1:0] xBase, yBase, xOrg, yOrg, hStep, vStep;
  logic signed [SW-1:0] relX, relY, colIdx;
  logic                 inX, inY;

  always_comb begin
    wS    = SW'(curW);
    hS    = SW'(curH);
    hcS   = SW'(hCount);
    vcS   = SW'(vCount);
    actWS = SW'(ACT_W);
    actLS = SW'(actLines);
    xBase = ((actWS - wS) >>> 2) <<< 1;
    yBase = ((actLS - hS) >>> 2) <<< 1;
    hStep = SW'({curHMag, 1'b0});
    vStep = SW'({curVMag, 1'b0});
    xOrg  = curHLeft ? (xBase - hStep) : (xBase + hStep);
    yOrg  = curVUp   ? (yBase - vStep) : (yBase + vStep);
    relX  = hcS - xOrg;
    relY  = vcS - yOrg;
    inX   = (relX >= 0) && (relX < wS);
    inY   = (relY >= 0) && (relY < hS);
    colIdx = curMirror ? (wS - 1 - relX) : relX;
  end

  always_comb begin
    pixReq          = activeNow && inX && inY;
    pixCol          = colIdx[PW_BITS-1:0];
    pixRow          = relY[PH_BITS-1:0];
    strobe.blank    = !activeNow;
    strobe.pic      = pixReq;
    strobe.crPhase  = hCount[0];
    strobe.oddField = oddField;
    strobe.bgSel    = curBg;
  end

  // R1
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hCount <= lineLast);

  // R1
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lineEnd |=> (hCount == '0));

  // R3
  field_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hCount != '0 || vCount != '0) |-> $stable(oddField));

  // R7
  clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixReq |-> (hCount < HW'(ACT_W) && vCount < actLines));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fieldEnd |=> $stable({curPal, curW, curH, curHMag, curHLeft,
                           curVMag, curVUp, curBg, curMirror}));

endmodule

// File: rtl/vout_pixel_path.sv
module vout_pixel_path
  import vout_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_t    strobe,
  input  logic [7:0] srcLuma,
  input  logic [7:0] srcChroma,
  output logic       blankOut,
  output logic       oddOut,
  output logic [7:0] lumaOut,
  output logic [7:0] chromaOut
);

  strobe_t     s1;
  logic [23:0] bgTriple;
  logic [7:0]  nextY, nextC;

  // stage 1: align control with the source's one-clock answer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= '0;
      s1.blank <= 1'b1;
    end else begin
      s1 <= strobe;
    end
  end

  always_comb begin
    bgTriple = bgColour(s1.bgSel);
    if (s1.blank) begin
      nextY = BLANK_LUMA;
      nextC = BLANK_CHROMA;
    end else if (s1.pic) begin
      nextY = srcLuma;
      nextC = srcChroma;
    end else begin
      nextY = bgTriple[23:16];
      nextC = s1.crPhase ? bgTriple[7:0] : bgTriple[15:8];
    end
  end

  // stage 2: registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blankOut  <= 1'b1;
      oddOut    <= 1'b0;
      lumaOut   <= BLANK_LUMA;
      chromaOut <= BLANK_CHROMA;
    end else begin
      blankOut  <= s1.blank;
      oddOut    <= s1.oddField;
      lumaOut   <= nextY;
      chromaOut <= nextC;
    end
  end

  // R4
  blank_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blankOut |-> (lumaOut == BLANK_LUMA && chromaOut == BLANK_CHROMA));

  // R6
  pic_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1.pic && !s1.blank) |=> (lumaOut == $past(srcLuma) && chromaOut == $past(srcChroma)));

endmodule

// File: rtl/vout_compositor.sv
module vout_compositor
  import vout_pkg::*;
#(
  parameter int ACT_W       = 720,
  parameter int LINE_A      = 858,
  parameter int LINE_B      = 864,
  parameter int ACT_LINES_A = 240,
  parameter int ACT_LINES_B = 288,
  parameter int VBL_A       = 22,
  parameter int VBL_B       = 24,
  parameter int PW_BITS     = 10,
  parameter int PH_BITS     = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               palMode,
  input  logic [PW_BITS-1:0] picWidth,
  input  logic [PH_BITS-1:0] picHeight,
  input  logic [5:0]         hShiftMag,
  input  logic               hShiftLeft,
  input  logic [4:0]         vShiftMag,
  input  logic               vShiftUp,
  input  logic [1:0]         bgSelect,
  input  logic               mirrorEn,
  output logic               pixReq,
  output logic [PW_BITS-1:0] pixCol,
  output logic [PH_BITS-1:0] pixRow,
  input  logic [7:0]         srcLuma,
  input  logic [7:0]         srcChroma,
  output logic               blankOut,
  output logic               oddFieldOut,
  output logic [7:0]         lumaOut,
  output logic [7:0]         chromaOut
);

  strobe_t strobe;

  vout_timing_ctrl #(
    .ACT_W(ACT_W), .LINE_A(LINE_A), .LINE_B(LINE_B),
    .ACT_LINES_A(ACT_LINES_A), .ACT_LINES_B(ACT_LINES_B),
    .VBL_A(VBL_A), .VBL_B(VBL_B), .PW_BITS(PW_BITS), .PH_BITS(PH_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .palMode(palMode),
    .picWidth(picWidth), .picHeight(picHeight),
    .hShiftMag(hShiftMag), .hShiftLeft(hShiftLeft),
    .vShiftMag(vShiftMag), .vShiftUp(vShiftUp),
    .bgSelect(bgSelect), .mirrorEn(mirrorEn),
    .pixReq(pixReq), .pixCol(pixCol), .pixRow(pixRow),
    .strobe(strobe)
  );

  vout_pixel_path u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .srcLuma(srcLuma), .srcChroma(srcChroma),
    .blankOut(blankOut), .oddOut(oddFieldOut),
    .lumaOut(lumaOut), .chromaOut(chromaOut)
  );

endmodule

// File: tb/sim_vout_compositor.sv
`timescale 1ns/1ps
module sim_vout_compositor;

  localparam int AW = 24, LA = 30, LB = 32, ALA = 10, ALB = 12, VA = 2, VB = 3;
  localparam int PWB = 10, PHB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic palMode = 1'b0;
  logic [PWB-1:0] picWidth = '0;
  logic [PHB-1:0] picHeight = '0;
  logic [5:0] hShiftMag = '0;
  logic hShiftLeft = 1'b0;
  logic [4:0] vShiftMag = '0;
  logic vShiftUp = 1'b0;
  logic [1:0] bgSelect = '0;
  logic mirrorEn = 1'b0;
  logic pixReq;
  logic [PWB-1:0] pixCol;
  logic [PHB-1:0] pixRow;
  logic [7:0] srcLuma = '0, srcChroma = '0;
  logic blankOut, oddFieldOut;
  logic [7:0] lumaOut, chromaOut;

  always #2 clk = ~clk;

  vout_compositor #(
    .ACT_W(AW), .LINE_A(LA), .LINE_B(LB), .ACT_LINES_A(ALA), .ACT_LINES_B(ALB),
    .VBL_A(VA), .VBL_B(VB), .PW_BITS(PWB), .PH_BITS(PHB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .palMode(palMode), .picWidth(picWidth), .picHeight(picHeight),
    .hShiftMag(hShiftMag), .hShiftLeft(hShiftLeft), .vShiftMag(vShiftMag), .vShiftUp(vShiftUp),
    .bgSelect(bgSelect), .mirrorEn(mirrorEn), .pixReq(pixReq), .pixCol(pixCol), .pixRow(pixRow),
    .srcLuma(srcLuma), .srcChroma(srcChroma), .blankOut(blankOut), .oddFieldOut(oddFieldOut),
    .lumaOut(lumaOut), .chromaOut(chromaOut)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  string phase = "R10 reset";

  function automatic int srcY(int c, int r); return (c*5 + r*17 + 3) & 255; endfunction
  function automatic int srcC(int c, int r); return ((c*11) ^ (r*3)) & 255; endfunction

  // pixel source: answers one clock after the request
  always @(posedge clk) begin
    srcLuma   <= pixReq ? 8'(srcY(int'(pixCol), int'(pixRow))) : 8'd0;
    srcChroma <= pixReq ? 8'(srcC(int'(pixCol), int'(pixRow))) : 8'd0;
  end

  // behavioural reference model
  int mh, mv, mpal, mw, mhh, mhm, mhl, mvm, mvu, mbg, mmir, modd;
  int e1[4], e2[4], e3[4];          // {blank, odd, Y, C}
  int expReq, expCol, expRow;

  task automatic evalPos(output int o[4], output int rq, output int cl, output int rw);
    int actL, xo, yo, rx, ry, y, c, bgY, bgCb, bgCr;
    bit act;
    actL = mpal ? ALB : ALA;
    act  = (mh < AW) && (mv < actL);
    xo = ((AW - mw) >>> 2) * 2 + (mhl ? -2*mhm : 2*mhm);
    yo = ((actL - mhh) >>> 2) * 2 + (mvu ? -2*mvm : 2*mvm);
    rx = mh - xo; ry = mv - yo;
    rq = (act && rx >= 0 && rx < mw && ry >= 0 && ry < mhh) ? 1 : 0;
    cl = mmir ? (mw - 1 - rx) : rx;
    rw = ry;
    case (mbg)
      1: begin bgY = 145; bgCb = 54;  bgCr = 34;  end
      2: begin bgY = 41;  bgCb = 240; bgCr = 110; end
      3: begin bgY = 106; bgCb = 202; bgCr = 222; end
      default: begin bgY = 16; bgCb = 128; bgCr = 128; end
    endcase
    if (!act) begin y = 16; c = 128; end
    else if (rq == 1) begin y = srcY(cl, rw); c = srcC(cl, rw); end
    else begin y = bgY; c = (mh % 2 == 1) ? bgCr : bgCb; end
    o[0] = act ? 0 : 1; o[1] = modd; o[2] = y; o[3] = c;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = LA - 1; mv = ALA + VA - 1; mpal = 0; mw = 0; mhh = 0; mhm = 0; mhl = 0;
      mvm = 0; mvu = 0; mbg = 0; mmir = 0; modd = 0;
      for (int i = 0; i < 4; i++) begin
        e1[i] = (i == 0) ? 1 : (i == 2) ? 16 : (i == 3) ? 128 : 0;
        e2[i] = e1[i]; e3[i] = e1[i];
      end
      expReq = 0; expCol = 0; expRow = 0;
    end else begin
      if (mh == (mpal ? LB : LA) - 1) begin
        mh = 0;
        if (mv == (mpal ? ALB + VB : ALA + VA) - 1) begin
          mv = 0; modd = 1 - modd;
          mpal = palMode; mw = picWidth; mhh = picHeight; mhm = hShiftMag; mhl = hShiftLeft;
          mvm = vShiftMag; mvu = vShiftUp; mbg = bgSelect; mmir = mirrorEn;
        end else mv = mv + 1;
      end else mh = mh + 1;
      e3 = e2; e2 = e1;
      evalPos(e1, expReq, expCol, expRow);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (blankOut !== e3[0][0]) begin
        mismatched++;
        $display("FAIL [R1 R2 %s] blankOut act=%0d exp=%0d", phase, blankOut, e3[0]);
      end
      compared++;
      if (oddFieldOut !== e3[1][0]) begin
        mismatched++;
        $display("FAIL [R3 %s] oddFieldOut act=%0d exp=%0d", phase, oddFieldOut, e3[1]);
      end
      compared++;
      if (lumaOut !== 8'(e3[2]) || chromaOut !== 8'(e3[3])) begin
        mismatched++;
        $display("FAIL [R4 R6 %s] Y/C act=%0d/%0d exp=%0d/%0d", phase, lumaOut, chromaOut, e3[2], e3[3]);
      end
      compared++;
      if (pixReq !== expReq[0] ||
          (expReq == 1 && (pixCol !== PWB'(expCol) || pixRow !== PHB'(expRow)))) begin
        mismatched++;
        $display("FAIL [R6 %s] req/col/row act=%0d/%0d/%0d exp=%0d/%0d/%0d",
                 phase, pixReq, pixCol, pixRow, expReq, expCol, expRow);
      end
    end
  end

  task automatic setCfg(int pal, int w, int h, int hm, int hl, int vm, int vu, int bg, int mir);
    @(negedge clk);
    palMode = pal[0]; picWidth = PWB'(w); picHeight = PHB'(h);
    hShiftMag = 6'(hm); hShiftLeft = hl[0]; vShiftMag = 5'(vm); vShiftUp = vu[0];
    bgSelect = 2'(bg); mirrorEn = mir[0];
  endtask

  task automatic runFields(int n);
    repeat (n * 500 + 37) @(posedge clk);
  endtask

  initial begin
    // R10: reset state at the ports
    repeat (3) @(negedge clk);
    compared++;
    if (!(blankOut === 1'b1 && lumaOut === 8'd16 && chromaOut === 8'd128 &&
          oddFieldOut === 1'b0 && pixReq === 1'b0)) begin
      mismatched++;
      $display("FAIL [R10] reset act=%0d/%0d/%0d/%0d/%0d exp=1/16/128/0/0",
               blankOut, lumaOut, chromaOut, oddFieldOut, pixReq);
    end
    @(negedge clk); rst_n = 1'b1;
    phase = "R10 first field";          runFields(1);
    phase = "R1 R2 R3 R5 R6 centred";   setCfg(0, 10, 6, 0, 0, 0, 0, 0, 0); runFields(3);
    phase = "R4 green";                 setCfg(0, 10, 6, 0, 0, 0, 0, 1, 0); runFields(2);
    phase = "R4 blue";                  setCfg(0, 8, 4, 0, 0, 0, 0, 2, 0);  runFields(2);
    phase = "R4 purple";                setCfg(0, 8, 4, 0, 0, 0, 0, 3, 0);  runFields(2);
    phase = "R5 right down";            setCfg(0, 10, 6, 2, 0, 1, 0, 1, 0); runFields(2);
    phase = "R5 left up";               setCfg(0, 10, 6, 3, 1, 1, 1, 2, 0); runFields(2);
    phase = "R7 clip right max";        setCfg(0, 10, 6, 63, 0, 31, 0, 3, 0); runFields(2);
    phase = "R7 clip left edge";        setCfg(0, 12, 8, 5, 1, 2, 1, 0, 0); runFields(2);
    phase = "R7 oversize";              setCfg(0, 30, 14, 0, 0, 0, 0, 1, 0); runFields(2);
    phase = "R8 mirror";                setCfg(0, 10, 6, 1, 0, 0, 0, 2, 1); runFields(2);
    phase = "R8 R7 mirror clipped";     setCfg(0, 14, 6, 6, 1, 0, 0, 3, 1); runFields(2);
    phase = "R1 R2 alt standard";       setCfg(1, 10, 8, 1, 0, 1, 0, 1, 0); runFields(3);
    phase = "R9 mid-field changes";
    for (int k = 0; k < 12; k++) begin
      setCfg(k % 2, 4 + 2*k, 2 + k, k, k % 3 == 0, k % 4, k % 2, k % 4, k % 2);
      repeat (97 + 41*k) @(posedge clk);
    end
    phase = "R2 back to 858";           setCfg(0, 6, 4, 0, 0, 0, 0, 0, 0); runFields(3);
    done = 1;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL [watchdog %s] run did not end act=hung exp=done", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule